// File: doc/BRIEF.md
# Cache Access Event Counter Unit

This unit sits beside a shared cache and observes its incoming cache-line requests together with the tag lookup result for each one. For every accepted request it updates a bank of saturating event counters: total requests, bytes looked up, hits, misses, per-type counts (read, write, atomic), non-temporal (streaming) requests and external coherence probes. A request whose line is held in the tag array is a hit. A request that misses the tags but targets a line whose fetch is already under way is also a hit. Only a miss on a line with no fetch in flight counts as a miss.

To tell these cases apart, the unit keeps a small table of line addresses that have missed and not yet been filled. A true miss takes a free slot in the table. A fill-complete strobe carrying the same line address releases that slot. The request side is a valid/ready stream. Ready drops only when a true miss finds the table full. While ready is low the requester must keep valid high and hold every request field stable. The request is accepted, and counted, on the first cycle in which ready is high. Tag hits and pending-line hits never stall. Software reads a counter by putting its index on a select input. A single-cycle clear input zeroes every counter.

Top module: `cache_event_counter`

## Requirements
- R1: After reset every counter reads zero, the pending table is empty and `req_ready` is high with `stall` low.
- R2: Each accepted request (`req_valid && req_ready`) adds 1 to the request counter (index 0) and `LINE_BYTES` to the byte counter (index 1), whatever part of the line is used. The new value is readable one cycle after acceptance.
- R3: `req_kind` encoding: 0 read, 1 write, 2 atomic without return, 3 atomic with return. Kind 0 counts at index 4 and kind 1 at index 5. Kinds 2 and 3 both count at index 6.
- R4: An accepted request with `req_stream` high also adds 1 to the streaming counter (index 7), in addition to its type counter.
- R5: An accepted request with `req_probe` high adds 1 to the probe counter (index 8).
- R6: An accepted request with `req_hit` high adds 1 to the hit counter (index 2) and does not touch the pending table.
- R7: An accepted request with `req_hit` low whose line address matches a pending entry adds 1 to the hit counter (index 2). It does not count as a miss and allocates nothing.
- R8: An accepted request with `req_hit` low and no pending match is a true miss. It adds 1 to the miss counter (index 3) and takes one pending slot.
- R9: `fill_valid` with an address that matches a pending entry frees that entry from the next cycle on. A fill that matches no entry changes nothing. Matching uses the table as it stands before that cycle's fill, so a request in the same cycle as the fill of its own line is a pending-line hit.
- R10: When the table is full, a true miss drives `req_ready` low and `stall` high, and nothing is counted. The requester holds the request. It is accepted in the cycle after a fill frees a slot. Hits of either kind are still accepted while the table is full.
- R11: Every counter saturates at all ones (2^`CNT_W`-1) and never wraps.
- R12: `cnt_clr` zeroes all counters on the next edge and takes priority over an event in the same cycle. It leaves the pending table unchanged.
- R13: `cnt_value` shows the counter picked by `cnt_sel` combinationally. Indices 9 and above read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | AW | Cache-line address of the request |
| req_kind | input | 2 | 0 read, 1 write, 2 atomic, 3 atomic with return |
| req_stream | input | 1 | Non-temporal (streaming) request |
| req_probe | input | 1 | External coherence probe |
| req_hit | input | 1 | Tag lookup hit for this request |
| fill_valid | input | 1 | Miss fill has completed |
| fill_addr | input | AW | Line address of the completed fill |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| cnt_sel | input | 4 | Counter index to read |
| cnt_value | output | CNT_W | Selected counter value |
| stall | output | 1 | True miss waiting for a free pending slot |

## Verification
A stale pending entry misclassifies a later request to its line. The hit counter rises where the miss counter should, one cycle after acceptance. A lost or never-written entry does the opposite and shows up as a second miss to the same line. A slot that is never freed, or freed twice, shows up at `req_ready` in the very cycle a true miss arrives. The port then either stalls when the table still has room, or accepts when it is full. Counter faults, such as a wrong step, a wrap instead of saturation, or a clear that loses to an event, are visible on the read port one cycle after the event that caused them.

// File: rtl/cec_pkg.sv
package cec_pkg;

  typedef enum logic [1:0] {
    KIND_READ     = 2'd0,
    KIND_WRITE    = 2'd1,
    KIND_ATOM     = 2'd2,
    KIND_ATOM_RET = 2'd3
  } req_kind_e;

  localparam int NUM_CNT   = 9;
  localparam int CNT_REQ   = 0;
  localparam int CNT_BYTES = 1;
  localparam int CNT_HIT   = 2;
  localparam int CNT_MISS  = 3;
  localparam int CNT_RD    = 4;
  localparam int CNT_WR    = 5;
  localparam int CNT_ATOM  = 6;
  localparam int CNT_STRM  = 7;
  localparam int CNT_PROBE = 8;

endpackage

// File: rtl/cec_sat_counter.sv
module cec_sat_counter #(
  parameter int W    = 32,
  parameter int STEP = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);

  logic [W:0] sum;

  assign sum = {1'b0, value} + (W+1)'(STEP);

  always_ff @(posedge clk) begin
    if (!rst_n)      value <= '0;
    else if (clr)    value <= '0;
    else if (inc)    value <= sum[W] ? '1 : sum[W-1:0];
  end

  // R11
  monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (value >= $past(value)));

  // R11
  saturate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && value == '1) |=> (value == '1));

  // R12
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (value == '0));

endmodule

// File: rtl/cec_miss_table.sv
module cec_miss_table #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] look_addr,
  input  logic          alloc,
  input  logic          fill_valid,
  input  logic [AW-1:0] fill_addr,
  output logic          hit_pending,
  output logic          full
);

  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] vld_q;
  logic [AW-1:0]    tag_q [DEPTH];
  logic [DEPTH-1:0] look_match;
  logic [DEPTH-1:0] fill_match;
  logic [DEPTH-1:0] free_oh;
  logic             found;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign look_match[i] = vld_q[i] && (tag_q[i] == look_addr);
    assign fill_match[i] = fill_valid && vld_q[i] && (tag_q[i] == fill_addr);

    always_ff @(posedge clk) begin
      if (!rst_n)                     tag_q[i] <= '0;
      else if (alloc && free_oh[i])   tag_q[i] <= look_addr;
    end
  end

  always_comb begin
    free_oh = '0;
    found   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= (vld_q & ~fill_match) | (alloc ? free_oh : '0);
  end

  assign hit_pending = |look_match;
  assign full        = &vld_q;

  // R7
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match) && $onehot0(fill_match));

  // R10
  no_alloc_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !full);

  // R8
  alloc_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !(|fill_match)) |=>
      (OCC_W'($countones(vld_q)) == OCC_W'($countones($past(vld_q)) + 1)));

  // R9
  fill_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc && (|fill_match)) |=>
      (OCC_W'($countones(vld_q)) + OCC_W'(1) == OCC_W'($countones($past(vld_q)))));

endmodule

// File: rtl/cec_event_decode.sv
module cec_event_decode
  import cec_pkg::*;
(
  input  logic               accept,
  input  req_kind_e          kind,
  input  logic               stream,
  input  logic               probe,
  input  logic               is_hit,
  input  logic               is_miss,
  output logic [NUM_CNT-1:0] inc
);

  always_comb begin
    inc            = '0;
    inc[CNT_REQ]   = accept;
    inc[CNT_BYTES] = accept;
    inc[CNT_HIT]   = accept && is_hit;
    inc[CNT_MISS]  = accept && is_miss;
    inc[CNT_RD]    = accept && (kind == KIND_READ);
    inc[CNT_WR]    = accept && (kind == KIND_WRITE);
    inc[CNT_ATOM]  = accept && ((kind == KIND_ATOM) || (kind == KIND_ATOM_RET));
    inc[CNT_STRM]  = accept && stream;
    inc[CNT_PROBE] = accept && probe;
  end

endmodule

// File: rtl/cache_event_counter.sv
module cache_event_counter
  import cec_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DEPTH      = 8,
  parameter int CNT_W      = 32,
  parameter int LINE_BYTES = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_kind,
  input  logic             req_stream,
  input  logic             req_probe,
  input  logic             req_hit,
  input  logic             fill_valid,
  input  logic [AW-1:0]    fill_addr,
  input  logic             cnt_clr,
  input  logic [3:0]       cnt_sel,
  output logic [CNT_W-1:0] cnt_value,
  output logic             stall
);

  localparam int SEL_W = 4;

  logic               pend_hit;
  logic               tbl_full;
  logic               true_miss;
  logic               accept;
  logic [NUM_CNT-1:0] inc_vec;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];

  assign true_miss = req_valid && !req_hit && !pend_hit;
  assign stall     = true_miss && tbl_full;
  assign req_ready = !stall;
  assign accept    = req_valid && req_ready;

  cec_miss_table #(.DEPTH(DEPTH), .AW(AW)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .look_addr   (req_addr),
    .alloc       (accept && true_miss),
    .fill_valid  (fill_valid),
    .fill_addr   (fill_addr),
    .hit_pending (pend_hit),
    .full        (tbl_full)
  );

  cec_event_decode u_decode (
    .accept  (accept),
    .kind    (req_kind_e'(req_kind)),
    .stream  (req_stream),
    .probe   (req_probe),
    .is_hit  (req_hit || pend_hit),
    .is_miss (true_miss),
    .inc     (inc_vec)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    localparam int STEP = (g == CNT_BYTES) ? LINE_BYTES : 1;
    cec_sat_counter #(.W(CNT_W), .STEP(STEP)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (inc_vec[g]),
      .value (cnt_q[g])
    );
  end

  always_comb begin
    cnt_value = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (cnt_sel == SEL_W'(i)) cnt_value = cnt_q[i];
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_hit)));

  // R10
  hit_never_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_hit) |-> req_ready);

  // R2
  req_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !cnt_clr) |=> $stable(cnt_q[CNT_REQ]));

endmodule

// File: tb/test_cache_event_counter.sv
module test_cache_event_counter;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 8;
  localparam int DEPTH      = 4;
  localparam int CNT_W      = 10;
  localparam int LB         = 64;
  localparam int MAXC       = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid, req_ready, req_stream, req_probe, req_hit;
  logic [AW-1:0]    req_addr, fill_addr;
  logic [1:0]       req_kind;
  logic             fill_valid, cnt_clr, stall;
  logic [3:0]       cnt_sel;
  logic [CNT_W-1:0] cnt_value;

  int errs   = 0;
  int checks = 0;
  int exp_c [9];
  bit pv [DEPTH];
  logic [AW-1:0] pa [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_event_counter #(.AW(AW), .DEPTH(DEPTH), .CNT_W(CNT_W), .LINE_BYTES(LB)) i_cache_event_counter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_stream(req_stream),
    .req_probe(req_probe), .req_hit(req_hit), .fill_valid(fill_valid),
    .fill_addr(fill_addr), .cnt_clr(cnt_clr), .cnt_sel(cnt_sel),
    .cnt_value(cnt_value), .stall(stall)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int sat(input int v, input int s);
    return (v + s > MAXC) ? MAXC : v + s;
  endfunction

  function automatic bit in_set(input logic [AW-1:0] a);
    for (int i = 0; i < DEPTH; i++) if (pv[i] && pa[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int occ();
    int n = 0;
    for (int i = 0; i < DEPTH; i++) if (pv[i]) n++;
    return n;
  endfunction

  function automatic void model_fill(input logic [AW-1:0] a);
    for (int i = 0; i < DEPTH; i++) if (pv[i] && pa[i] == a) pv[i] = 1'b0;
  endfunction

  function automatic void model_alloc(input logic [AW-1:0] a);
    for (int i = 0; i < DEPTH; i++) begin
      if (!pv[i]) begin
        pv[i] = 1'b1;
        pa[i] = a;
        return;
      end
    end
  endfunction

  // One cycle of request (and optional fill); caller keeps the request up while stalled.
  task automatic step(input logic [AW-1:0] a, input logic [1:0] k, input bit s, input bit p,
                      input bit h, input bit fv, input logic [AW-1:0] fa, input string tag);
    bit m, tm, st;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k; req_stream = s; req_probe = p; req_hit = h;
    fill_valid = fv; fill_addr = fa;
    #1;
    m  = in_set(a);
    tm = !h && !m;
    st = tm && (occ() == DEPTH);
    chk(req_ready == !st, {tag, " R10 ready"}, int'(req_ready), int'(!st));
    chk(stall == st, {tag, " R10 stall"}, int'(stall), int'(st));
    @(posedge clk);
    if (!st) begin
      exp_c[0] = sat(exp_c[0], 1);
      exp_c[1] = sat(exp_c[1], LB);
      if (!tm) exp_c[2] = sat(exp_c[2], 1);
      else     exp_c[3] = sat(exp_c[3], 1);
      if (k == 2'd0) exp_c[4] = sat(exp_c[4], 1);
      if (k == 2'd1) exp_c[5] = sat(exp_c[5], 1);
      if (k[1])      exp_c[6] = sat(exp_c[6], 1);
      if (s) exp_c[7] = sat(exp_c[7], 1);
      if (p) exp_c[8] = sat(exp_c[8], 1);
    end
    if (fv) model_fill(fa);
    if (tm && !st) model_alloc(a);
  endtask

  task automatic fill_only(input logic [AW-1:0] fa);
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b1; fill_addr = fa;
    @(posedge clk);
    model_fill(fa);
  endtask

  task automatic clear_cnt(input bit with_req);
    @(negedge clk);
    cnt_clr = 1'b1; fill_valid = 1'b0;
    req_valid = with_req; req_addr = 8'd55; req_hit = 1'b1; req_kind = 2'd0;
    req_stream = 1'b0; req_probe = 1'b0;
    @(posedge clk);
    for (int i = 0; i < 9; i++) exp_c[i] = 0;
    @(negedge clk);
    cnt_clr = 1'b0; req_valid = 1'b0;
  endtask

  task automatic check_all(input string tag);
    string rt [16];
    rt[0] = "R2"; rt[1] = "R2/R11"; rt[2] = "R6/R7"; rt[3] = "R8"; rt[4] = "R3";
    rt[5] = "R3"; rt[6] = "R3"; rt[7] = "R4"; rt[8] = "R5";
    for (int i = 9; i < 16; i++) rt[i] = "R13";
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b0;
    for (int i = 0; i < 16; i++) begin
      int ev;
      cnt_sel = 4'(i);
      #1;
      ev = (i < 9) ? exp_c[i] : 0;
      chk(int'(cnt_value) == ev, $sformatf("%s %s idx%0d", tag, rt[i], i), int'(cnt_value), ev);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) exp_c[i] = 0;
    for (int i = 0; i < DEPTH; i++) begin pv[i] = 1'b0; pa[i] = '0; end
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_kind = '0; req_stream = 1'b0;
    req_probe = 1'b0; req_hit = 1'b0; fill_valid = 1'b0; fill_addr = '0;
    cnt_clr = 1'b0; cnt_sel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(stall == 1'b0, "R1 stall after reset", int'(stall), 0);
    check_all("R1 reset");

    // Sweep every kind/stream/probe combination with tag hits; 16*LB saturates bytes.
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 2; p++)
          step(8'(k*4 + s*2 + p), 2'(k), s[0], p[0], 1'b1, 1'b0, '0, "R6 sweep");
    check_all("R11 sweep");

    clear_cnt(1'b1);
    check_all("R12 clear over event");

    // True misses fill the table.
    for (int i = 0; i < DEPTH; i++) step(8'(10 + i), 2'(i), 1'b0, 1'b0, 1'b0, 1'b0, '0, "R8 miss");
    check_all("R8 misses");

    step(8'd11, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R7 pending hit");
    step(8'd50, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, '0, "R10 hit while full");
    check_all("R7 pending hit");

    // Full-table stall, released by a fill in the last stalled cycle.
    step(8'd20, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R10 stall a");
    step(8'd20, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R10 stall b");
    step(8'd20, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd12, "R10 stall fill");
    step(8'd20, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R10 accept");
    check_all("R10 after stall");

    // Unmatched fill frees nothing.
    fill_only(8'd99);
    step(8'd77, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R9 unmatched fill");
    step(8'd77, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 8'd10, "R9 real fill");
    step(8'd77, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R9 accept");
    check_all("R9 fills");

    // Fill and request to the same line in one cycle: pending hit, then a new miss.
    step(8'd13, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'd13, "R9 same-cycle");
    step(8'd13, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R9 refetch");
    check_all("R9 same-cycle");

    // Clear keeps the table.
    clear_cnt(1'b0);
    step(8'd11, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R12 table kept");
    check_all("R12 table kept");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule